// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt Controller

This block watches a group of external input lines and records a sticky pending flag for each line when a selected transition is seen on it. For every line, software picks whether a rising transition, a falling transition, or either one counts as a trigger. Each input is first brought into the local clock domain through a two-stage synchroniser. A change is then found by comparing the synchronised value with its value one cycle earlier. A line held at a steady level never retriggers.

Software reaches four registers through a single-cycle bus with valid, write, address and data signals. Read data comes back on the cycle after the request. The registers are an interrupt enable mask at offset 0x00, the rising select at 0x08, the falling select at 0x0C and the pending flags at 0x14. A pending flag is cleared by writing 1 to its bit. Each line's interrupt output is high while that line's pending flag is set and the line is unmasked.

The lines run from 0 to 19, except that line 18 is not implemented. A rising transition that is detected in the same cycle as a bus write to the rising select register is discarded.

Top module: `edge_line_irq`

## Requirements
- R1: After reset, all four registers read as zero, `irq_out` is zero and `bus_rdata` is zero.
- R2: With its rising select bit set, a line that goes high just before clock edge k has its pending flag set, and its interrupt output (if unmasked) high, after clock edge k+2 and not before.
- R3: With its falling select bit set, a line that goes low sets its pending flag with the same three-edge latency.
- R4: A line with both select bits set triggers on either transition.
- R5: A level held steady produces no further trigger after its pending flag has been cleared.
- R6: Bit 18 and bits 31:20 of the mask, rising select and falling select registers ignore writes and read as zero. A transition on line 18 never sets a pending flag.
- R7: Writing 1 to a bit of the pending register (offset 0x14) clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R8: If a qualified transition and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: `irq_out[i]` equals pending bit i ANDed with mask bit i (offset 0x00, 1 = enabled). Pending flags still latch while their line is masked.
- R10: A rising transition detected in the same cycle as a bus write to offset 0x08 does not set a pending flag. Later rising transitions are recorded normally.
- R11: A read returns its data on `bus_rdata` one cycle after the request. Offsets other than 0x00, 0x08, 0x0C and 0x14 read as zero, and writes to them change nothing.
- R12: A transition on a line whose select bit for that direction is clear sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_LINES | Asynchronous external lines |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read, zero otherwise |
| irq_out | output | NUM_LINES | Per-line interrupt, pending AND mask |

## Verification
The hardest situation to reach is a rising transition that reaches the edge detector in exactly the cycle in which a write to the rising select register is on the bus. The same alignment is needed for a transition that lands on a flag in the cycle it is being cleared. The stimulus changes the line half a cycle before a clock edge and waits two more edges, which covers both synchroniser stages. It then drives the bus write on the following falling edge, so the write and the detection fall on the same rising edge. A control transition without the write then shows that the line is still enabled.

// File: rtl/eli_pkg.sv
package eli_pkg;
  localparam int unsigned OFF_MASK = 'h00;
  localparam int unsigned OFF_RISE = 'h08;
  localparam int unsigned OFF_FALL = 'h0C;
  localparam int unsigned OFF_PEND = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_RISE,
    SEL_FALL,
    SEL_PEND
  } reg_sel_e;
endpackage

// File: rtl/eli_sync.sv
module eli_sync #(
  parameter int WIDTH  = 20,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eli_edge.sv
module eli_edge #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_in,
  output logic [WIDTH-1:0] rise_det,
  output logic [WIDTH-1:0] fall_det
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_in;
  end

  assign rise_det = level_in & ~prev_q;
  assign fall_det = ~level_in & prev_q;

  // a held level may report a transition for one cycle only
  AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (rst)
    ((rise_det & $past(rise_det)) == '0) && ((fall_det & $past(fall_det)) == '0)); // R5
endmodule

// File: rtl/eli_regs.sv
module eli_regs
  import eli_pkg::*;
#(
  parameter int NUM_LINES = 20,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_LINES-1:0] LINE_PRESENT = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_LINES-1:0] rise_det,
  input  logic [NUM_LINES-1:0] fall_det,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq
);
  localparam int PAD_W = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0] mask_q, rise_q, fall_q, pend_q;
  logic [NUM_LINES-1:0] mask_d, rise_d, fall_d, pend_d;
  logic [NUM_LINES-1:0] wdata_l, clr_vec, hit, hit_raw, rd_val;
  logic [DATA_W-1:0]    rdata_q;
  logic [NUM_LINES-1:0] irq_q;
  logic                 wr_en, rd_en, rise_block;
  reg_sel_e             sel;

  assign wr_en   = bus_valid & bus_write;
  assign rd_en   = bus_valid & ~bus_write;
  assign wdata_l = bus_wdata[NUM_LINES-1:0] & LINE_PRESENT;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_MASK): sel = SEL_MASK;
      ADDR_W'(OFF_RISE): sel = SEL_RISE;
      ADDR_W'(OFF_FALL): sel = SEL_FALL;
      ADDR_W'(OFF_PEND): sel = SEL_PEND;
      default:           sel = SEL_NONE;
    endcase
  end

  // trigger qualification; rising edges are dropped during a rise-select write
  assign rise_block = wr_en && (sel == SEL_RISE);
  assign hit_raw    = (rise_det & rise_q) | (fall_det & fall_q);
  assign hit        = ((rise_det & rise_q & {NUM_LINES{~rise_block}})
                     | (fall_det & fall_q)) & LINE_PRESENT;
  assign clr_vec    = (wr_en && sel == SEL_PEND) ? wdata_l : '0;

  always_comb begin
    mask_d = mask_q;
    rise_d = rise_q;
    fall_d = fall_q;
    if (wr_en) begin
      case (sel)
        SEL_MASK: mask_d = wdata_l;
        SEL_RISE: rise_d = wdata_l;
        SEL_FALL: fall_d = wdata_l;
        default:  ;
      endcase
    end
    pend_d = (pend_q & ~clr_vec) | hit;
  end

  always_comb begin
    case (sel)
      SEL_MASK: rd_val = mask_q;
      SEL_RISE: rd_val = rise_q;
      SEL_FALL: rd_val = fall_q;
      SEL_PEND: rd_val = pend_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      pend_q  <= '0;
      irq_q   <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      pend_q  <= pend_d;
      irq_q   <= pend_d & mask_d;
      rdata_q <= rd_en ? {{PAD_W{1'b0}}, rd_val} : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0); // R7
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~$past(pend_q) & ~$past(hit_raw)) == '0); // R12
  AST_RISE_WR_DROP: assert property (@(posedge clk) disable iff (rst)
    rise_block |=> ((pend_q & ~$past(pend_q) & $past(rise_det)) == '0)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_q & ~mask_q) == '0); // R9
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata_q == '0)); // R11
endmodule

// File: rtl/edge_line_irq.sv
module edge_line_irq #(
  parameter int NUM_LINES = 20,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] LINE_PRESENT = 20'hB_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] line_sync, rise_det, fall_det;

  eli_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (line_in),
    .sync_out (line_sync)
  );

  eli_edge #(.WIDTH(NUM_LINES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (line_sync),
    .rise_det (rise_det),
    .fall_det (fall_det)
  );

  eli_regs #(
    .NUM_LINES    (NUM_LINES),
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .LINE_PRESENT (LINE_PRESENT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rise_det  (rise_det),
    .fall_det  (fall_det),
    .bus_rdata (bus_rdata),
    .irq       (irq_out)
  );
endmodule

// File: tb/test_edge_line_irq.sv
module test_edge_line_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] line_in = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [19:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] rise_cfg, fall_cfg, mask_cfg, rv;

  always #4 clk = ~clk;

  edge_line_irq i_edge_line_irq (
    .clk(clk), .rst(rst), .line_in(line_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {addr, write data, expected read-back}
  localparam logic [71:0] VEC [9] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h000B_FFFF},  // R6
    {8'h08, 32'hFFFF_FFFF, 32'h000B_FFFF},  // R6
    {8'h0C, 32'h1234_5678, 32'h0000_5678},  // R6
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h0C, 32'h0000_0000, 32'h0000_0000},
    {8'h08, 32'h0000_0000, 32'h0000_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    step(1);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    chk("R1 irq after reset", 32'(irq_out), 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    bus_rd(8'h00, rv); chk("R1 mask reset", rv, 32'h0);
    bus_rd(8'h08, rv); chk("R1 rise reset", rv, 32'h0);
    bus_rd(8'h0C, rv); chk("R1 fall reset", rv, 32'h0);
    bus_rd(8'h14, rv); chk("R1 pend reset", rv, 32'h0);

    for (int i = 0; i < 9; i++) begin
      bus_wr(VEC[i][71:64], VEC[i][63:32]);
      bus_rd(VEC[i][71:64], rv);
      chk($sformatf("R6/R11 table entry %0d", i), rv, VEC[i][31:0]);
    end
    step(1);
    chk("R11 rdata idle after read", bus_rdata, 32'h0);

    mask_cfg = 32'h000F_FFFF & ~(32'h1 << 9);
    rise_cfg = (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 11);
    fall_cfg = (32'h1 << 5) | (32'h1 << 7);
    bus_wr(8'h00, mask_cfg);
    bus_wr(8'h08, rise_cfg);
    bus_wr(8'h0C, fall_cfg);

    // R2 latency: change before edge 1, flag after edge 3
    line_in[3] = 1'b1;
    step(2);
    chk("R2 not yet after two edges", 32'(irq_out[3]), 32'h0);
    step(1);
    chk("R2 rising sets flag", 32'(irq_out[3]), 32'h1);

    // R7 clear, R5 held level no retrigger
    bus_wr(8'h14, 32'h1 << 3);
    step(8);
    chk("R5 held level no retrigger", 32'(irq_out[3]), 32'h0);
    line_in[3] = 1'b0;
    step(5);
    chk("R12 fall on rise-only line", 32'(irq_out[3]), 32'h0);

    // R3 / R12 on falling-only line
    line_in[5] = 1'b1;
    step(5);
    chk("R12 rise on fall-only line", 32'(irq_out[5]), 32'h0);
    line_in[5] = 1'b0;
    step(5);
    chk("R3 falling sets flag", 32'(irq_out[5]), 32'h1);
    bus_wr(8'h14, 32'h1 << 5);

    // R4 both directions
    line_in[7] = 1'b1;
    step(5);
    chk("R4 rise on both-edge line", 32'(irq_out[7]), 32'h1);
    bus_wr(8'h14, 32'h1 << 7);
    chk("R7 write-one clears", 32'(irq_out[7]), 32'h0);
    line_in[7] = 1'b0;
    step(5);
    chk("R4 fall on both-edge line", 32'(irq_out[7]), 32'h1);
    bus_wr(8'h14, 32'h0);
    chk("R7 write-zero keeps flag", 32'(irq_out[7]), 32'h1);

    // R8: edge lands on the same edge as the clearing write
    line_in[7] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1 << 7;
    step(1);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R8 edge wins over clear", 32'(irq_out[7]), 32'h1);
    bus_wr(8'h14, 32'h1 << 7);
    chk("R7 clear after collision", 32'(irq_out[7]), 32'h0);

    // R9 masked line still latches
    line_in[9] = 1'b1;
    step(5);
    chk("R9 masked line no irq", 32'(irq_out[9]), 32'h0);
    bus_rd(8'h14, rv);
    chk("R9 masked line still pends", rv, 32'h1 << 9);
    mask_cfg = mask_cfg | (32'h1 << 9);
    bus_wr(8'h00, mask_cfg);
    chk("R9 unmask raises irq", 32'(irq_out[9]), 32'h1);

    // R6 line 18 never pends
    bus_wr(8'h08, rise_cfg | (32'h1 << 18));
    bus_wr(8'h0C, fall_cfg | (32'h1 << 18));
    line_in[18] = 1'b1;
    step(5);
    line_in[18] = 1'b0;
    step(5);
    bus_rd(8'h14, rv);
    chk("R6 line 18 never pends", rv, 32'h1 << 9);
    chk("R6 line 18 irq low", 32'(irq_out[18]), 32'h0);

    // R10 rising edge coincident with rise-select write
    line_in[11] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h08; bus_wdata = rise_cfg;
    step(1);
    bus_valid = 1'b0; bus_write = 1'b0;
    step(4);
    chk("R10 edge during rise write dropped", 32'(irq_out[11]), 32'h0);
    bus_rd(8'h14, rv);
    chk("R10 pending unchanged", rv, 32'h1 << 9);
    line_in[11] = 1'b0;
    step(5);
    line_in[11] = 1'b1;
    step(5);
    chk("R10 later rise recorded", 32'(irq_out[11]), 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule